// File: doc/BRIEF.md
# Sector Advance and Result Builder

This block belongs to a diskette controller. It tracks the cylinder, head and sector of the current data transfer. It moves the position forward each time a sector finishes, and it spots the last sector of a track. It then chooses how the command ends. A command ends normally when the terminal count arrives. It ends abnormally when the transfer tries to run past the end of the track. At the end, the block fills in the status bytes and assembles the seven-byte result packet that the host reads back.

End of track is handled in two stages. When the position lands on the last sector of the last head in use, the block only raises a flag. If another sector then finishes without terminal count, the command is aborted, the DMA request is dropped and no further advance is made. If terminal count arrives with the flag raised, the block clears the flag and steps the position once more. The packet therefore reports the sector after the one last transferred.

A command is loaded with `startCmd`. It is closed by `idleReq` once the host has taken the packet. Format and read-ID commands use the same packet and the same terminal-count ending, but they never move the position.

Top module: `sector_result_unit`

## Requirements
- R1: After reset, st0, st1, st2 and the position are 0, irq, resultStrobe and stopDrq are low, and mainStatus is 0x80.
- R2: In a read (cmdKind 0) or write (cmdKind 1) transfer, each sectorDone without termCount and without end of track set raises curSector by 1 in the next cycle. sectorDone outside a transfer has no effect on the position or on irq.
- R3: When sectorDone advances a position whose sector is at or above sectorsPerTrack with multiTrack low, the sector becomes 1, the cylinder rises by 1 and the head is unchanged.
- R4: With multiTrack high, the same wrap toggles the head. The cylinder rises only when the head goes from 1 back to 0.
- R5: The cylinder never steps above maxCylinder. A step from maxCylinder leaves it at maxCylinder.
- R6: An advance without termCount that lands on head == multiTrack and sector == sectorsPerTrack sets st1 bit 7 (end of track).
- R7: sectorDone without termCount while st1 bit 7 is set leaves the position unchanged. It sets st0 to 0x40 | head<<2 | drive (bits 7:6 = 01 mark abnormal end), pulses stopDrq for one cycle and starts the result phase.
- R8: sectorDone with termCount while end of track is clear advances once. It sets st0 to head<<2 | drive using the advanced head, clears st2, keeps st1 and starts the result phase.
- R9: In a read or write, sectorDone with termCount while end of track is set does not advance at once. It then applies one final advance, clears st1 bit 7 and rewrites st0 bit 2 with the new head.
- R10: The packet resultBytes holds, from byte 0 (bits 7:0) up, st0, st1, st2, cylinder, head, sector and the size code 2. resultStrobe is a one-cycle pulse when the packet is valid, and irq rises with it and stays high until idle.
- R11: For format (cmdKind 2) and read-ID (cmdKind 3), sectorDone never changes the position or st1. termCount ends the command normally, with no final advance.
- R12: idleReq in the result phase clears st1, st2 and irq, keeps st0, and sets mainStatus to 0x80 | its low four bits.
- R13: startCmd loads the position and the drive (driveSelect, the low two bits of the digital output register) and sets mainStatus to 0x10 | driveBusy (bit 4 busy, bit 7 ready clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startCmd | input | 1 | Load a new command |
| cmdKind | input | 2 | 0 read, 1 write, 2 format, 3 read-ID |
| startCyl | input | CYL_W | Starting cylinder |
| startHead | input | 1 | Starting head |
| startSector | input | SEC_W | Starting sector |
| multiTrack | input | 1 | Multi-track mode |
| driveSelect | input | 2 | Drive number, low bits of the digital output register |
| driveBusy | input | 4 | Drive-busy bits for mainStatus |
| sectorsPerTrack | input | SEC_W | Sectors per track of the medium |
| maxCylinder | input | CYL_W | Highest legal cylinder |
| sectorDone | input | 1 | One sector finished |
| termCount | input | 1 | Terminal count, valid with sectorDone |
| idleReq | input | 1 | Return to idle after the result is read |
| st0 | output | 8 | Status register 0 |
| st1 | output | 8 | Status register 1 |
| st2 | output | 8 | Status register 2 |
| curCyl | output | CYL_W | Current cylinder |
| curHead | output | 1 | Current head |
| curSector | output | SEC_W | Current sector |
| mainStatus | output | 8 | Main status byte |
| resultBytes | output | 56 | Seven-byte result packet |
| resultStrobe | output | 1 | Packet ready pulse |
| irq | output | 1 | Interrupt request |
| stopDrq | output | 1 | Drop DMA request pulse |

## Verification
Transfers are started just before the track boundary and just after it, in both single-track and multi-track mode. The only thing that changes between them is whether terminal count arrives with the end-of-track flag already raised. This separates the three endings: an advance that only flags, the abort, and the final extra step with its head-bit rewrite. A start at the highest cylinder separates clamping from wrapping. A format command, and a sectorDone sent while idle, show that the position stays still when it must.

// File: rtl/secadv_pkg.sv
package secadv_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_XFER,
    PH_FINAL,
    PH_PACK,
    PH_RESULT
  } phase_t;

  typedef enum logic [1:0] {
    KIND_READ   = 2'd0,
    KIND_WRITE  = 2'd1,
    KIND_FORMAT = 2'd2,
    KIND_READID = 2'd3
  } cmdKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic advance;
    logic evalEot;
    logic normalEnd;
    logic abortEnd;
    logic finalStep;
    logic latchPacket;
    logic goIdle;
  } advStrobes_t;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned PKT_BYTES = 7;
  localparam logic [7:0]  SIZE_CODE = 8'd2;
  localparam int unsigned EOT_BIT   = 7;
  localparam logic [1:0]  END_OK    = 2'b00;
  localparam logic [1:0]  END_ABORT = 2'b01;

endpackage

// File: rtl/secadv_control.sv
module secadv_control
  import secadv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startCmd,
  input  logic        sectorDone,
  input  logic        termCount,
  input  logic        idleReq,
  input  logic        eotFlag,
  input  logic        isRw,
  output advStrobes_t stb,
  output logic        resultStrobe,
  output logic        stopDrq
);

  phase_t phase, phaseNext;

  always_comb begin
    stb       = '0;
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: begin
        if (startCmd) begin
          stb.loadStart = 1'b1;
          phaseNext     = PH_XFER;
        end
      end
      PH_XFER: begin
        if (sectorDone) begin
          if (!isRw) begin
            if (termCount) begin
              stb.normalEnd = 1'b1;
              phaseNext     = PH_FINAL;
            end
          end else if (termCount) begin
            stb.normalEnd = 1'b1;
            stb.advance   = !eotFlag;
            phaseNext     = PH_FINAL;
          end else if (eotFlag) begin
            stb.abortEnd = 1'b1;
            phaseNext    = PH_PACK;
          end else begin
            stb.advance = 1'b1;
            stb.evalEot = 1'b1;
          end
        end
      end
      PH_FINAL: begin
        stb.finalStep = 1'b1;
        phaseNext     = PH_PACK;
      end
      PH_PACK: begin
        stb.latchPacket = 1'b1;
        phaseNext       = PH_RESULT;
      end
      PH_RESULT: begin
        if (idleReq) begin
          stb.goIdle = 1'b1;
          phaseNext  = PH_IDLE;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase        <= PH_IDLE;
      resultStrobe <= 1'b0;
      stopDrq      <= 1'b0;
    end else begin
      phase        <= phaseNext;
      resultStrobe <= stb.latchPacket;
      stopDrq      <= stb.abortEnd;
    end
  end

endmodule

// File: rtl/secadv_datapath.sv
module secadv_datapath
  import secadv_pkg::*;
#(
  parameter int unsigned CYL_W = 8,
  parameter int unsigned SEC_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  advStrobes_t                   stb,
  input  logic [1:0]                    cmdKind,
  input  logic [CYL_W-1:0]              startCyl,
  input  logic                          startHead,
  input  logic [SEC_W-1:0]              startSector,
  input  logic                          multiTrack,
  input  logic [1:0]                    driveSelect,
  input  logic [3:0]                    driveBusy,
  input  logic [SEC_W-1:0]              sectorsPerTrack,
  input  logic [CYL_W-1:0]              maxCylinder,
  output logic [7:0]                    st0,
  output logic [7:0]                    st1,
  output logic [7:0]                    st2,
  output logic [CYL_W-1:0]              curCyl,
  output logic                          curHead,
  output logic [SEC_W-1:0]              curSector,
  output logic [7:0]                    mainStatus,
  output logic [PKT_BYTES*BYTE_W-1:0]   resultBytes,
  output logic                          irq,
  output logic                          eotFlag,
  output logic                          isRw
);

  logic [1:0]       drive;
  cmdKind_t         kind;
  logic             mtMode;

  logic             atLast;
  logic [SEC_W-1:0] incSector;
  logic             incHead;
  logic             cylStep;
  logic [CYL_W-1:0] incCyl;
  logic             eotHit;
  logic             headNow;
  logic             finalMove;

  // next position after one sector
  always_comb begin
    atLast    = (curSector >= sectorsPerTrack);
    incSector = atLast ? SEC_W'(1) : curSector + SEC_W'(1);
    incHead   = (atLast && mtMode) ? ~curHead : curHead;
    cylStep   = atLast && (!mtMode || curHead);
    if (!cylStep)
      incCyl = curCyl;
    else if (curCyl >= maxCylinder)
      incCyl = maxCylinder;
    else
      incCyl = curCyl + CYL_W'(1);
    eotHit    = (incHead == mtMode) && (incSector == sectorsPerTrack);
    headNow   = stb.advance ? incHead : curHead;
  end

  assign eotFlag   = st1[EOT_BIT];
  assign isRw      = (kind == KIND_READ) || (kind == KIND_WRITE);
  assign finalMove = stb.finalStep && (st0[7:6] == END_OK) && eotFlag && isRw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCyl      <= '0;
      curHead     <= 1'b0;
      curSector   <= '0;
      drive       <= '0;
      kind        <= KIND_READ;
      mtMode      <= 1'b0;
      st0         <= '0;
      st1         <= '0;
      st2         <= '0;
      mainStatus  <= 8'h80;
      resultBytes <= '0;
      irq         <= 1'b0;
    end else begin
      if (stb.loadStart) begin
        curCyl     <= startCyl;
        curHead    <= startHead;
        curSector  <= startSector;
        drive      <= driveSelect;
        kind       <= cmdKind_t'(cmdKind);
        mtMode     <= multiTrack;
        st1        <= '0;
        st2        <= '0;
        mainStatus <= {4'b0001, driveBusy};
      end
      if (stb.advance || finalMove) begin
        curCyl    <= incCyl;
        curHead   <= incHead;
        curSector <= incSector;
      end
      if (stb.advance && stb.evalEot && eotHit)
        st1[EOT_BIT] <= 1'b1;
      if (stb.normalEnd) begin
        st0 <= {END_OK, 3'b000, headNow, drive};
        st2 <= '0;
      end
      if (stb.abortEnd)
        st0 <= {END_ABORT, 3'b000, curHead, drive};
      if (finalMove) begin
        st1[EOT_BIT] <= 1'b0;
        st0[2]       <= incHead;
      end
      if (stb.latchPacket) begin
        resultBytes <= {SIZE_CODE, 8'(curSector), 8'(curHead), 8'(curCyl),
                        st2, st1, st0};
        irq         <= 1'b1;
      end
      if (stb.goIdle) begin
        st1        <= '0;
        st2        <= '0;
        mainStatus <= {4'b1000, mainStatus[3:0]};
        irq        <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sector_result_unit.sv
module sector_result_unit
  import secadv_pkg::*;
#(
  parameter int unsigned CYL_W = 8,
  parameter int unsigned SEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startCmd,
  input  logic [1:0]       cmdKind,
  input  logic [CYL_W-1:0] startCyl,
  input  logic             startHead,
  input  logic [SEC_W-1:0] startSector,
  input  logic             multiTrack,
  input  logic [1:0]       driveSelect,
  input  logic [3:0]       driveBusy,
  input  logic [SEC_W-1:0] sectorsPerTrack,
  input  logic [CYL_W-1:0] maxCylinder,
  input  logic             sectorDone,
  input  logic             termCount,
  input  logic             idleReq,
  output logic [7:0]       st0,
  output logic [7:0]       st1,
  output logic [7:0]       st2,
  output logic [CYL_W-1:0] curCyl,
  output logic             curHead,
  output logic [SEC_W-1:0] curSector,
  output logic [7:0]       mainStatus,
  output logic [55:0]      resultBytes,
  output logic             resultStrobe,
  output logic             irq,
  output logic             stopDrq
);

  advStrobes_t stb;
  logic        eotFlag;
  logic        isRw;

  secadv_control i_control (
    .clk          (clk),
    .rstN         (rstN),
    .startCmd     (startCmd),
    .sectorDone   (sectorDone),
    .termCount    (termCount),
    .idleReq      (idleReq),
    .eotFlag      (eotFlag),
    .isRw         (isRw),
    .stb          (stb),
    .resultStrobe (resultStrobe),
    .stopDrq      (stopDrq)
  );

  secadv_datapath #(
    .CYL_W (CYL_W),
    .SEC_W (SEC_W)
  ) i_datapath (
    .clk             (clk),
    .rstN            (rstN),
    .stb             (stb),
    .cmdKind         (cmdKind),
    .startCyl        (startCyl),
    .startHead       (startHead),
    .startSector     (startSector),
    .multiTrack      (multiTrack),
    .driveSelect     (driveSelect),
    .driveBusy       (driveBusy),
    .sectorsPerTrack (sectorsPerTrack),
    .maxCylinder     (maxCylinder),
    .st0             (st0),
    .st1             (st1),
    .st2             (st2),
    .curCyl          (curCyl),
    .curHead         (curHead),
    .curSector       (curSector),
    .mainStatus      (mainStatus),
    .resultBytes     (resultBytes),
    .irq             (irq),
    .eotFlag         (eotFlag),
    .isRw            (isRw)
  );

endmodule

// File: rtl/sector_result_unit_chk.sv
module sector_result_unit_chk #(
  parameter int unsigned SEC_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             idleReq,
  input logic [7:0]       st0,
  input logic [7:0]       st1,
  input logic [7:0]       st2,
  input logic [7:0]       mainStatus,
  input logic [SEC_W-1:0] curSector,
  input logic             resultStrobe,
  input logic             irq,
  input logic             stopDrq
);

  assert_strobe_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    resultStrobe |=> !resultStrobe);

  assert_irq_with_packet_R10: assert property (@(posedge clk) disable iff (!rstN)
    resultStrobe |-> irq);

  assert_irq_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !idleReq) |=> irq);

  assert_abort_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    stopDrq |-> (st0[7:6] == 2'b01));

  assert_abort_no_move_R7: assert property (@(posedge clk) disable iff (!rstN)
    stopDrq |-> $stable(curSector));

  assert_stopdrq_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    stopDrq |=> !stopDrq);

  assert_idle_clears_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> (st1 == 8'h00 && st2 == 8'h00 && mainStatus[7]));

  assert_ready_busy_R13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({mainStatus[7], mainStatus[4]}));

endmodule

bind sector_result_unit sector_result_unit_chk #(.SEC_W(SEC_W)) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .idleReq      (idleReq),
  .st0          (st0),
  .st1          (st1),
  .st2          (st2),
  .mainStatus   (mainStatus),
  .curSector    (curSector),
  .resultStrobe (resultStrobe),
  .irq          (irq),
  .stopDrq      (stopDrq)
);

// File: tb/test_sector_result_unit.sv
module test_sector_result_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startCmd = 1'b0;
  logic [1:0]  cmdKind = 2'd0;
  logic [7:0]  startCyl = 8'd0;
  logic        startHead = 1'b0;
  logic [7:0]  startSector = 8'd0;
  logic        multiTrack = 1'b0;
  logic [1:0]  driveSelect = 2'd0;
  logic [3:0]  driveBusy = 4'd0;
  logic [7:0]  sectorsPerTrack = 8'd18;
  logic [7:0]  maxCylinder = 8'd79;
  logic        sectorDone = 1'b0;
  logic        termCount = 1'b0;
  logic        idleReq = 1'b0;
  logic [7:0]  st0, st1, st2, curCyl, curSector, mainStatus;
  logic        curHead, resultStrobe, irq, stopDrq;
  logic [55:0] resultBytes;

  int checks = 0;
  int errors = 0;
  bit dropSeen = 1'b0;

  always #10 clk = ~clk;

  always @(negedge clk) if (stopDrq) dropSeen = 1'b1;

  sector_result_unit i_sector_result_unit (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .cmdKind(cmdKind),
    .startCyl(startCyl), .startHead(startHead), .startSector(startSector),
    .multiTrack(multiTrack), .driveSelect(driveSelect), .driveBusy(driveBusy),
    .sectorsPerTrack(sectorsPerTrack), .maxCylinder(maxCylinder),
    .sectorDone(sectorDone), .termCount(termCount), .idleReq(idleReq),
    .st0(st0), .st1(st1), .st2(st2), .curCyl(curCyl), .curHead(curHead),
    .curSector(curSector), .mainStatus(mainStatus), .resultBytes(resultBytes),
    .resultStrobe(resultStrobe), .irq(irq), .stopDrq(stopDrq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [55:0] pkt(input logic [7:0] s0, s1, s2, cyl, hd, sec);
    return {8'h02, sec, hd, cyl, s2, s1, s0};
  endfunction

  task automatic startOp(input logic [1:0] kind, input logic [7:0] cyl,
                         input logic hd, input logic [7:0] sec,
                         input logic mt, input logic [1:0] drv);
    @(negedge clk);
    startCmd = 1'b1; cmdKind = kind; startCyl = cyl; startHead = hd;
    startSector = sec; multiTrack = mt; driveSelect = drv;
    @(negedge clk);
    startCmd = 1'b0;
    dropSeen = 1'b0;
  endtask

  task automatic sector(input logic tc);
    @(negedge clk);
    sectorDone = 1'b1; termCount = tc;
    @(negedge clk);
    sectorDone = 1'b0; termCount = 1'b0;
  endtask

  task automatic waitPacket(input string tag);
    int n = 0;
    while (!resultStrobe && n < 20) begin @(negedge clk); n++; end
    check({tag, " resultStrobe/irq"}, {resultStrobe, irq}, 2'b11);
  endtask

  task automatic goIdle();
    @(negedge clk); idleReq = 1'b1;
    @(negedge clk); idleReq = 1'b0;
  endtask

  task automatic testReset();
    check("R1 st0/st1/st2", {st0, st1, st2}, 24'h0);
    check("R1 mainStatus", mainStatus, 8'h80);
    check("R1 irq/strobe/stopDrq", {irq, resultStrobe, stopDrq}, 3'b000);
    check("R1 position", {curCyl, curHead, curSector}, 17'h0);
  endtask

  task automatic testPlainRead();
    driveBusy = 4'b0010;
    startOp(2'd0, 8'd3, 1'b0, 8'd5, 1'b0, 2'd1);
    check("R13 mainStatus after start", mainStatus, 8'h12);
    sector(1'b0);
    check("R2 sector advance", curSector, 8'd6);
    check("R2 no result yet", irq, 1'b0);
    sector(1'b1);
    waitPacket("R8");
    check("R8 R10 packet normal end", resultBytes, pkt(8'h01, 8'h00, 8'h00, 8'd3, 8'd0, 8'd7));
    goIdle();
    check("R12 mainStatus idle", mainStatus, 8'h82);
    check("R12 irq low, st0 kept", {irq, st0}, {1'b0, 8'h01});
  endtask

  task automatic testAbort();
    startOp(2'd0, 8'd10, 1'b0, 8'd17, 1'b0, 2'd2);
    sector(1'b0);
    check("R6 eot flag single track", st1, 8'h80);
    check("R6 sector at end", curSector, 8'd18);
    sector(1'b0);
    waitPacket("R7");
    check("R7 abnormal st0", st0, 8'h42);
    check("R7 stopDrq pulse seen", dropSeen, 1'b1);
    check("R7 R10 abort packet", resultBytes, pkt(8'h42, 8'h80, 8'h00, 8'd10, 8'd0, 8'd18));
    goIdle();
    check("R12 st1 cleared, st0 kept", {st1, st0}, {8'h00, 8'h42});
  endtask

  task automatic testEotThenTc();
    startOp(2'd1, 8'd10, 1'b0, 8'd17, 1'b0, 2'd0);
    sector(1'b0);
    check("R6 eot flag on write", st1, 8'h80);
    sector(1'b1);
    waitPacket("R9");
    check("R9 final advance packet", resultBytes, pkt(8'h00, 8'h00, 8'h00, 8'd11, 8'd0, 8'd1));
    check("R9 no abort", dropSeen, 1'b0);
    goIdle();
  endtask

  task automatic testMultiTrack();
    startOp(2'd0, 8'd4, 1'b0, 8'd18, 1'b1, 2'd3);
    sector(1'b0);
    check("R4 head toggles, same cylinder", {curCyl, curHead, curSector}, {8'd4, 1'b1, 8'd1});
    check("R6 no eot on head 1 sector 1", st1, 8'h00);
    sector(1'b1);
    waitPacket("R8 mt");
    check("R8 st0 head bit", resultBytes, pkt(8'h07, 8'h00, 8'h00, 8'd4, 8'd1, 8'd2));
    goIdle();
    startOp(2'd0, 8'd4, 1'b1, 8'd17, 1'b1, 2'd3);
    sector(1'b0);
    check("R6 eot flag multi track", st1, 8'h80);
    sector(1'b1);
    waitPacket("R9 mt");
    check("R9 R4 head rewrite and cylinder step", resultBytes,
          pkt(8'h03, 8'h00, 8'h00, 8'd5, 8'd0, 8'd1));
    goIdle();
  endtask

  task automatic testWrapAndClamp();
    startOp(2'd0, 8'd20, 1'b0, 8'd18, 1'b0, 2'd0);
    sector(1'b0);
    check("R3 single-track wrap", {curCyl, curHead, curSector}, {8'd21, 1'b0, 8'd1});
    sector(1'b1);
    waitPacket("R3");
    check("R3 packet after wrap", resultBytes, pkt(8'h00, 8'h00, 8'h00, 8'd21, 8'd0, 8'd2));
    goIdle();
    startOp(2'd0, 8'd79, 1'b0, 8'd18, 1'b0, 2'd0);
    sector(1'b1);
    waitPacket("R5");
    check("R5 cylinder clamped", resultBytes, pkt(8'h00, 8'h00, 8'h00, 8'd79, 8'd0, 8'd1));
    goIdle();
  endtask

  task automatic testFormat();
    startOp(2'd2, 8'd7, 1'b1, 8'd3, 1'b0, 2'd0);
    sector(1'b0);
    check("R11 format keeps position", {curCyl, curHead, curSector, st1}, {8'd7, 1'b1, 8'd3, 8'h00});
    sector(1'b1);
    waitPacket("R11");
    check("R11 format packet", resultBytes, pkt(8'h04, 8'h00, 8'h00, 8'd7, 8'd1, 8'd3));
    goIdle();
    sector(1'b1);
    repeat (4) @(negedge clk);
    check("R2 sectorDone ignored when idle", {curSector, irq, resultStrobe}, {8'd3, 1'b0, 1'b0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testPlainRead();
    testAbort();
    testEotThenTc();
    testMultiTrack();
    testWrapAndClamp();
    testFormat();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R10 actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule